// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block performs the stack-based operations of a small 8-bit processor core. It owns the 8-bit stack pointer and runs eight commands over a byte-wide synchronous memory port:

- push or pull a plain byte;
- push or pull the status byte;
- subroutine call and return;
- software break through a fixed vector;
- return from interrupt.

Opcode decode and flag arithmetic stay outside the block. The core hands over a command code together with the operand byte, the current PC, the call target and the status byte. It collects the pulled byte, the new PC, the new status byte and the stack pointer once the done pulse arrives.

The command side is a valid/ready stream. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. The data inputs are sampled only on that edge. `cmd_ready` stays low from acceptance until the done pulse, so a source holding `cmd_valid` high simply waits. A command offered while the block is busy is not taken.

The memory port issues at most one access per cycle. Read data must be returned on `mem_rdata` in the cycle after the read request. Result outputs are plain registers that hold their value until a later command updates them.

Top module: `stk_xfer_seq`

## Requirements
- R1: Command codes on `cmd_code` are 0 push byte, 1 pull byte, 2 push status, 3 pull status, 4 call, 5 return, 6 break, 7 return from interrupt. `cmd_ready` is high when idle and low from the accepting edge until `done`. `done` is a one-cycle pulse.
- R2: A push writes at address 0x0100+SP and then decrements SP modulo 256. SP 0x00 becomes 0xFF. Every write goes to page 0x01.
- R3: A pull first increments SP modulo 256 and then reads at 0x0100+SP. SP 0xFF becomes 0x00. A plain pull reports the byte on `pull_byte`.
- R4: Push status writes `status_in` unchanged. Pull status sets `status_out` to the pulled byte with bit 5 forced to 1.
- R5: A call writes the high byte of PC-1 (16-bit wrap) first and the low byte second, then sets `pc_out` to `call_target`.
- R6: A return pulls the low byte and then the high byte, and sets `pc_out` to that value plus 1, wrapping at 16 bits.
- R7: A break writes PC high, then PC low, then `status_in` with bit 4 set. It then reads 0xFFFE (new PC low) and 0xFFFF (new PC high). It sets `status_out` to `status_in` with bits 4 and 2 set, and lowers SP by 3.
- R8: A return from interrupt pulls status (bit 5 forced to 1), then PC low, then PC high. It loads `pc_out` with that value and no increment, and raises SP by 3.
- R9: With n memory accesses in a command (1, 1, 1, 1, 2, 2, 5, 3 for codes 0..7), `done` rises on the (n+1)th rising edge after the accepting edge.
- R10: After reset SP, `pull_byte`, `pc_out` and `status_out` are 0. A result output that a command does not produce keeps its previous value.
- R11: A command presented while the block is busy is not accepted. It causes no memory access, no SP change and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_code | input | 3 | Command code (R1) |
| push_byte | input | 8 | Byte for push byte |
| pc_in | input | 16 | Current PC for call and break |
| call_target | input | 16 | Destination of a call |
| status_in | input | 8 | Status byte for push status and break |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read request |
| pull_byte | output | 8 | Last byte taken by a plain pull |
| pc_out | output | 16 | PC produced by call, return, break or return from interrupt |
| status_out | output | 8 | Status produced by pull status, break or return from interrupt |
| sp_out | output | 8 | Stack pointer |
| done | output | 1 | Command complete pulse |

## Verification
A stack pointer that is off by one shows up on the very next access. It appears as a wrong address on `mem_addr`, and one cycle later as a wrong `sp_out`. A full sweep of pushes and pulls around the 256-entry ring therefore exposes it within one command. A wrong capture slot or byte order leaves SP intact but swaps or duplicates PC bytes on `pc_out` at the done pulse. A step-count error moves `done` off its expected cycle or leaves `cmd_ready` low. Break and return-from-interrupt round trips across several PC and status values therefore compare every write, the final PC and status, and the latency.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    CMD_PUSH  = 3'd0,
    CMD_PULL  = 3'd1,
    CMD_PUSHP = 3'd2,
    CMD_PULLP = 3'd3,
    CMD_CALL  = 3'd4,
    CMD_RET   = 3'd5,
    CMD_BRK   = 3'd6,
    CMD_RTI   = 3'd7
  } stk_cmd_e;

  typedef enum logic [1:0] {
    AK_NONE,
    AK_PUSH,
    AK_PULL,
    AK_VEC
  } acc_kind_e;

  typedef enum logic [2:0] {
    WS_DIN,
    WS_STAT,
    WS_RETHI,
    WS_RETLO,
    WS_PCHI,
    WS_PCLO,
    WS_BRKST
  } wsel_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec,
  input  logic            inc,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);
  assign sp_up = sp + SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= '0;
    else if (dec) sp <= sp - SP_W'(1);
    else if (inc) sp <= sp_up;
  end

  // R2/R3: the pointer never moves both ways at once
  p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && inc));
endmodule

// File: rtl/stk_plan.sv
module stk_plan
  import stk_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  stk_cmd_e          cmd,
  input  logic [STEP_W-1:0] step,
  output acc_kind_e         kind,
  output wsel_e             wsel,
  output logic              vec_hi,
  output logic [STEP_W-1:0] nacc
);
  always_comb begin
    kind   = AK_NONE;
    wsel   = WS_DIN;
    vec_hi = 1'b0;
    nacc   = STEP_W'(1);
    unique case (cmd)
      CMD_PUSH:  kind = AK_PUSH;
      CMD_PUSHP: begin kind = AK_PUSH; wsel = WS_STAT; end
      CMD_PULL, CMD_PULLP: kind = AK_PULL;
      CMD_CALL: begin
        nacc = STEP_W'(2);
        kind = AK_PUSH;
        wsel = (step == '0) ? WS_RETHI : WS_RETLO;
      end
      CMD_RET: begin nacc = STEP_W'(2); kind = AK_PULL; end
      CMD_BRK: begin
        nacc = STEP_W'(5);
        case (step)
          STEP_W'(0): begin kind = AK_PUSH; wsel = WS_PCHI;  end
          STEP_W'(1): begin kind = AK_PUSH; wsel = WS_PCLO;  end
          STEP_W'(2): begin kind = AK_PUSH; wsel = WS_BRKST; end
          default: begin kind = AK_VEC; vec_hi = (step == STEP_W'(4)); end
        endcase
      end
      CMD_RTI: begin nacc = STEP_W'(3); kind = AK_PULL; end
      default: ;
    endcase
    if (step >= nacc) kind = AK_NONE;
  end
endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
  import stk_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
  parameter int          B_BIT      = 4,
  parameter int          I_BIT      = 2,
  parameter int          ONE_BIT    = 5,
  parameter int          STEP_W     = 3,
  parameter int          NSLOT      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_code,
  input  logic [7:0]  push_byte,
  input  logic [15:0] pc_in,
  input  logic [15:0] call_target,
  input  logic [7:0]  status_in,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  pull_byte,
  output logic [15:0] pc_out,
  output logic [7:0]  status_out,
  output logic [7:0]  sp_out,
  output logic        done
);
  localparam int          SLOT_W = $clog2(NSLOT);
  localparam logic [7:0]  B_MASK = 8'(1 << B_BIT);
  localparam logic [7:0]  I_MASK = 8'(1 << I_BIT);
  localparam logic [7:0]  F_MASK = 8'(1 << ONE_BIT);

  logic              busy;
  stk_cmd_e          cmd_q;
  logic [STEP_W-1:0] step, nacc;
  logic [7:0]        din_q, st_q;
  logic [15:0]       pc_q, tgt_q, ret_addr;
  logic              rd_pend;
  logic [SLOT_W-1:0] rd_slot, rd_cnt;
  logic [NSLOT-1:0][7:0] merged;
  acc_kind_e         kind;
  wsel_e             wsel;
  logic              vec_hi, issue, finish, accept, is_rd;
  logic [7:0]        sp, sp_up;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign issue     = busy && (step < nacc);
  assign finish    = busy && (step == nacc);
  assign is_rd     = (kind == AK_PULL) || (kind == AK_VEC);
  assign ret_addr  = pc_q - 16'd1;
  assign sp_out    = sp;

  stk_plan #(.STEP_W(STEP_W)) u_plan (
    .cmd(cmd_q), .step(step), .kind(kind), .wsel(wsel),
    .vec_hi(vec_hi), .nacc(nacc)
  );

  stk_ptr #(.SP_W(8)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .dec(issue && (kind == AK_PUSH)),
    .inc(issue && (kind == AK_PULL)),
    .sp(sp), .sp_up(sp_up)
  );

  // memory request
  always_comb begin
    mem_en   = issue && (kind != AK_NONE);
    mem_we   = issue && (kind == AK_PUSH);
    mem_addr = '0;
    case (kind)
      AK_PUSH: mem_addr = {STACK_PAGE, sp};
      AK_PULL: mem_addr = {STACK_PAGE, sp_up};
      AK_VEC:  mem_addr = VEC_ADDR + 16'(vec_hi);
      default: mem_addr = '0;
    endcase
    case (wsel)
      WS_STAT:  mem_wdata = st_q;
      WS_RETHI: mem_wdata = ret_addr[15:8];
      WS_RETLO: mem_wdata = ret_addr[7:0];
      WS_PCHI:  mem_wdata = pc_q[15:8];
      WS_PCLO:  mem_wdata = pc_q[7:0];
      WS_BRKST: mem_wdata = st_q | B_MASK;
      default:  mem_wdata = din_q;
    endcase
  end

  // read-capture slots, one per read of a command
  for (genvar g = 0; g < NSLOT; g++) begin : g_cap
    logic [7:0] cap_r;
    logic       hit;
    assign hit = rd_pend && (rd_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   cap_r <= '0;
      else if (hit) cap_r <= mem_rdata;
    end
    assign merged[g] = hit ? mem_rdata : cap_r;
  end

  // sequencing and results
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cmd_q      <= CMD_PUSH;
      step       <= '0;
      din_q      <= '0;
      st_q       <= '0;
      pc_q       <= '0;
      tgt_q      <= '0;
      rd_pend    <= 1'b0;
      rd_slot    <= '0;
      rd_cnt     <= '0;
      pull_byte  <= '0;
      pc_out     <= '0;
      status_out <= '0;
      done       <= 1'b0;
    end else begin
      done    <= 1'b0;
      rd_pend <= issue && is_rd;
      if (accept) begin
        busy   <= 1'b1;
        cmd_q  <= stk_cmd_e'(cmd_code);
        step   <= '0;
        rd_cnt <= '0;
        din_q  <= push_byte;
        st_q   <= status_in;
        pc_q   <= pc_in;
        tgt_q  <= call_target;
      end
      if (issue) begin
        step    <= step + STEP_W'(1);
        rd_slot <= rd_cnt;
        if (is_rd) rd_cnt <= rd_cnt + SLOT_W'(1);
      end
      if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        case (cmd_q)
          CMD_PULL:  pull_byte  <= merged[0];
          CMD_PULLP: status_out <= merged[0] | F_MASK;
          CMD_CALL:  pc_out     <= tgt_q;
          CMD_RET:   pc_out     <= {merged[1], merged[0]} + 16'd1;
          CMD_BRK: begin
            pc_out     <= {merged[1], merged[0]};
            status_out <= st_q | B_MASK | I_MASK;
          end
          CMD_RTI: begin
            status_out <= merged[0] | F_MASK;
            pc_out     <= {merged[2], merged[1]};
          end
          default: ;
        endcase
      end
    end
  end

  // R2: every write lands in the stack page and SP steps down after it
  p_push_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == STACK_PAGE));
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (sp_out == $past(mem_addr[7:0]) - 8'd1));
  // R3: a stack read uses the already-incremented pointer
  p_pull_preinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && (mem_addr[15:8] == STACK_PAGE)) |=>
    (sp_out == $past(mem_addr[7:0])));
  // R1: single-cycle done, no access while ready, ready back with done
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !cmd_ready);
  p_done_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  // R4/R8: a pulled status always shows bit 5 set
  p_fixed_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ((cmd_q == CMD_PULLP) || (cmd_q == CMD_RTI))) |-> status_out[ONE_BIT]);
  // R7: break leaves B and I set
  p_brk_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cmd_q == CMD_BRK)) |-> (status_out[B_BIT] && status_out[I_BIT]));
endmodule

// File: tb/stk_xfer_seq_tb.sv
`timescale 1ns/1ps
module stk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_code = '0;
  logic [7:0]  push_byte = '0;
  logic [15:0] pc_in = '0;
  logic [15:0] call_target = '0;
  logic [7:0]  status_in = '0;
  logic        mem_en, mem_we, done;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, pull_byte, status_out, sp_out;
  logic [7:0]  mem_rdata = '0;

  always #4 clk = ~clk;

  stk_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .push_byte(push_byte), .pc_in(pc_in),
    .call_target(call_target), .status_in(status_in), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pull_byte(pull_byte), .pc_out(pc_out),
    .status_out(status_out), .sp_out(sp_out), .done(done)
  );

  // memory model: stack page plus the two vector bytes
  logic [7:0]  page [256];
  logic [7:0]  vec_lo = 8'h34, vec_hi = 8'hC2;
  logic [15:0] log_a [1024];
  logic [7:0]  log_d [1024];
  int          wr_n = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        page[mem_addr[7:0]] <= mem_wdata;
        log_a[wr_n % 1024] <= mem_addr;
        log_d[wr_n % 1024] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else if (mem_addr == 16'hFFFE) mem_rdata <= vec_lo;
      else if (mem_addr == 16'hFFFF)     mem_rdata <= vec_hi;
      else if (mem_addr[15:8] == 8'h01)  mem_rdata <= page[mem_addr[7:0]];
      else                               mem_rdata <= 8'h00;
    end
  end

  int n_cmp = 0, n_bad = 0, base = 0, lat = 0;
  bit ended = 1'b0;
  logic [7:0]  esp = 8'h00;
  logic [7:0]  shadow [256];
  logic [7:0]  exp_pull = 8'h00;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nacc(input logic [2:0] c);
    case (c)
      3'd4, 3'd5: return 2;
      3'd6:       return 5;
      3'd7:       return 3;
      default:    return 1;
    endcase
  endfunction

  task automatic run(input logic [2:0] c, input logic [7:0] d,
                     input logic [15:0] p, input logic [15:0] t,
                     input logic [7:0] s, input bit poke);
    @(negedge clk);
    base = wr_n;
    cmd_code = c; push_byte = d; pc_in = p; call_target = t; status_in = s;
    cmd_valid = 1'b1;
    chk("R1", "ready idle", 32'(cmd_ready), 32'd1);
    @(posedge clk);
    #1;
    cmd_valid = poke;
    if (poke) cmd_code = 3'd1;
    lat = 0;
    while (lat < 20) begin
      @(negedge clk);
      lat++;
      if (done) begin cmd_valid = 1'b0; break; end
      if (poke) chk("R11", "ready busy", 32'(cmd_ready), 32'd0);
    end
    chk("R9", "latency", lat, nacc(c) + 2);
    chk("R1", "ready at done", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    chk("R1", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic exp_wr(input string req, input int k, input logic [7:0] data);
    chk(req, "write addr", 32'(log_a[(base + k) % 1024]), {16'h0, 8'h01, esp});
    chk(req, "write data", 32'(log_d[(base + k) % 1024]), 32'(data));
    shadow[esp] = data;
    esp = esp - 8'd1;
  endtask

  initial begin
    logic [15:0] pcs [5] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h80FF, 16'h0100};
    logic [15:0] exp_pc;
    logic [7:0]  exp_st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset sp", 32'(sp_out), 32'd0);
    chk("R10", "reset pc", 32'(pc_out), 32'd0);
    chk("R10", "reset status", 32'(status_out), 32'd0);
    chk("R10", "reset pull", 32'(pull_byte), 32'd0);
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R1", "reset ready", 32'(cmd_ready), 32'd1);
    exp_pc = 16'h0; exp_st = 8'h0;

    // R2: 256 pushes sweep the pointer once around the ring
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      run(3'd0, v, 16'hBEEF, 16'h1111, 8'hAA, 1'b0);
      chk("R2", "write count", wr_n - base, 1);
      exp_wr("R2", 0, v);
      chk("R2", "sp", 32'(sp_out), 32'(esp));
      chk("R10", "pc held", 32'(pc_out), 32'(exp_pc));
      chk("R10", "status held", 32'(status_out), 32'(exp_st));
    end
    // R3: 256 pulls return the bytes newest first
    for (int i = 0; i < 256; i++) begin
      run(3'd1, 8'h00, 16'h0, 16'h0, 8'h0, 1'b0);
      esp = esp + 8'd1;
      exp_pull = shadow[esp];
      chk("R3", "pull byte", 32'(pull_byte), 32'(exp_pull));
      chk("R3", "sp", 32'(sp_out), 32'(esp));
      chk("R3", "no write", wr_n - base, 0);
    end
    // R4: every status value through push and pull
    for (int s = 0; s < 256; s++) begin
      run(3'd2, 8'h00, 16'h0, 16'h0, 8'(s), 1'b0);
      exp_wr("R4", 0, 8'(s));
      chk("R10", "pull held", 32'(pull_byte), 32'(exp_pull));
      run(3'd3, 8'h00, 16'h0, 16'h0, 8'h00, 1'b0);
      esp = esp + 8'd1;
      exp_st = shadow[esp] | 8'h20;
      chk("R4", "pulled status", 32'(status_out), 32'(exp_st));
      chk("R4", "sp", 32'(sp_out), 32'(esp));
    end
    // R5/R6: call and return round trips
    for (int k = 0; k < 5; k++) begin
      logic [15:0] r;
      r = pcs[k] - 16'd1;
      run(3'd4, 8'h00, pcs[k], pcs[k] ^ 16'hA5C3, 8'h00, 1'b0);
      chk("R5", "write count", wr_n - base, 2);
      exp_wr("R5", 0, r[15:8]);
      exp_wr("R5", 1, r[7:0]);
      chk("R5", "target", 32'(pc_out), 32'(pcs[k] ^ 16'hA5C3));
      chk("R5", "sp", 32'(sp_out), 32'(esp));
      run(3'd5, 8'h00, 16'h0, 16'h0, 8'h00, 1'b0);
      esp = esp + 8'd2;
      chk("R6", "return pc", 32'(pc_out), 32'(pcs[k]));
      chk("R6", "sp", 32'(sp_out), 32'(esp));
      chk("R10", "status held", 32'(status_out), 32'(exp_st));
    end
    // R6: return from 0xFFFF wraps to 0x0000
    run(3'd0, 8'hFF, 16'h0, 16'h0, 8'h0, 1'b0);
    exp_wr("R6", 0, 8'hFF);
    run(3'd0, 8'hFF, 16'h0, 16'h0, 8'h0, 1'b0);
    exp_wr("R6", 0, 8'hFF);
    run(3'd5, 8'h00, 16'h0, 16'h0, 8'h00, 1'b0);
    esp = esp + 8'd2;
    chk("R6", "wrap pc", 32'(pc_out), 32'h0000);
    // R7/R8/R11: break and return from interrupt
    for (int k = 0; k < 4; k++) begin
      logic [7:0] s;
      s = 8'(k * 83 + 1);
      vec_lo = 8'(k * 29 + 3);
      vec_hi = 8'(k * 61 + 200);
      run(3'd6, 8'h00, pcs[k + 1], 16'h0, s, k == 1);
      chk("R7", "write count", wr_n - base, 3);
      exp_wr("R7", 0, pcs[k + 1][15:8]);
      exp_wr("R7", 1, pcs[k + 1][7:0]);
      exp_wr("R7", 2, s | 8'h10);
      chk("R7", "vector pc", 32'(pc_out), {16'h0, vec_hi, vec_lo});
      chk("R7", "status", 32'(status_out), 32'(s | 8'h14));
      chk("R7", "sp", 32'(sp_out), 32'(esp));
      if (k == 1) begin
        repeat (3) begin
          @(negedge clk);
          chk("R11", "no extra done", 32'(done), 32'd0);
        end
        chk("R11", "sp unchanged", 32'(sp_out), 32'(esp));
        chk("R11", "pull unchanged", 32'(pull_byte), 32'(exp_pull));
      end
      run(3'd7, 8'h00, 16'h0, 16'h0, 8'h00, 1'b0);
      esp = esp + 8'd3;
      chk("R8", "status", 32'(status_out), 32'(s | 8'h30));
      chk("R8", "pc", 32'(pc_out), 32'(pcs[k + 1]));
      chk("R8", "sp", 32'(sp_out), 32'(esp));
    end
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule